// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 32 interrupt request lines into a single interrupt output for a processor. Software programs it through a simple word-addressed register port. Each line has its own mode word and its own vector word. The mode word holds a 3-bit priority and a trigger type. Lines are switched on and off through set-only and clear-only command words, and the current enable set can be read back as one word.

When the processor takes the interrupt, it reads the fetch word. That read returns the vector of the best pending, enabled line. It also records the line's priority on an internal nesting stack that is eight entries deep. An end-of-service write removes the top entry. While the stack holds entries, only lines with a strictly higher priority than the top entry can raise the output. That is what allows nested handlers.

If no line qualifies, the fetch returns a programmable spurious value and leaves the stack alone. A small debug word is stored and read back but has no function. Every read returns its data in the same cycle as the read strobe. Write data, and the side effects of a read, take effect at the next rising clock edge.

Top module: `vic_top`

## Requirements
- R1: A write to the enable command word (0x82) sets the enable of each line whose data bit is 1. A write to the disable command word (0x83) clears the enable of each line whose data bit is 1. Lines whose data bit is 0 keep their enable. The mask word (0x85) reads back the enables, with bit i standing for line i.
- R2: A write to the clear command word (0x84) drops the latched edge request of every line whose data bit is 1. It has no effect on a level-triggered line whose input is still active.
- R3: The mode word of line i (address 0x00+i) holds the priority in bits [2:0] and the trigger type in bits [5:4]. The type encodings are 0 = high level, 1 = rising edge, 2 = low level and 3 = falling edge. Both fields read back as written. The vector word of line i sits at 0x40+i.
- R4: Types 2 and 3 are accepted only on lines marked external and on the fast line (line 0). On any other line, a mode write that asks for type 2 or 3 keeps the previous type but still updates the priority.
- R5: A level line requests for as long as its input sits at the active level and stops when the input leaves it. An edge line latches a request on the selected transition and holds it after the input returns.
- R6: A read of the fetch word (0x80) returns the vector of the qualifying line with the highest priority. Among lines with equal priority, the lowest line number wins.
- R7: When no line qualifies, a fetch returns the spurious word (0x81) and leaves the nesting stack unchanged.
- R8: The interrupt output is high exactly when some enabled, requesting line has a priority strictly above the stack top. When the stack is empty, any priority counts.
- R9: A fetch that finds a winner pushes that line's priority onto the stack and clears the winner's latched edge request.
- R10: A write to the end-of-service word (0x86) pops one stack entry, and a pop on an empty stack is ignored. The stack holds eight nested levels.
- R11: After reset, all lines are disabled and nothing is latched. The stack is empty. The spurious word, all mode words and all vector words are zero.
- R12: The debug word (0x87) stores bits [1:0] and reads them back, with no effect on interrupt behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe; a fetch read has side effects |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of busRdEn |
| srcIn | input | 32 | Interrupt request lines, synchronous to clk |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
The properties assume that a read strobe and a write strobe never arrive in the same cycle. They also assume the request lines are already synchronous to the clock. The bench drives every bus access as a single-strobe transaction that lasts one cycle, and it changes the request lines only on the falling clock edge.

The stack assertions also rely on there being no more distinct priority levels than stack entries. The bench reaches full depth only by enabling lines in ascending priority order.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // trigger encodings: bit0 = edge sensitive, bit1 = active low / falling
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_VEC,
    SEL_FETCH,
    SEL_SPUR,
    SEL_MASK,
    SEL_DEBUG
  } rdSel_e;

  localparam logic [7:0] ADR_FETCH = 8'h80;
  localparam logic [7:0] ADR_SPUR  = 8'h81;
  localparam logic [7:0] ADR_ENA   = 8'h82;
  localparam logic [7:0] ADR_DIS   = 8'h83;
  localparam logic [7:0] ADR_CLR   = 8'h84;
  localparam logic [7:0] ADR_MASK  = 8'h85;
  localparam logic [7:0] ADR_EOI   = 8'h86;
  localparam logic [7:0] ADR_DBG   = 8'h87;

  // strobes from decode to datapath
  typedef struct packed {
    logic       wrMode;
    logic       wrVec;
    logic       wrSpur;
    logic       wrEna;
    logic       wrDis;
    logic       wrClr;
    logic       wrEoi;
    logic       wrDbg;
    logic       fetch;
    logic [5:0] idx;
    rdSel_e     rdSel;
  } ctrl_t;

endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic [7:0] busAddr,
  output ctrl_t      strobes
);

  localparam logic [6:0] SRC_LIM = 7'(NUM_SRC);

  logic inRange;
  logic inMode;
  logic inVec;
  logic doRd;

  assign inRange = ({1'b0, busAddr[5:0]} < SRC_LIM);
  assign inMode  = (busAddr[7:6] == 2'b00) && inRange;
  assign inVec   = (busAddr[7:6] == 2'b01) && inRange;
  assign doRd    = busRdEn && !busWrEn;

  always_comb begin
    strobes       = '0;
    strobes.idx   = busAddr[5:0];
    strobes.rdSel = SEL_NONE;
    if (busWrEn) begin
      strobes.wrMode = inMode;
      strobes.wrVec  = inVec;
      strobes.wrSpur = (busAddr == ADR_SPUR);
      strobes.wrEna  = (busAddr == ADR_ENA);
      strobes.wrDis  = (busAddr == ADR_DIS);
      strobes.wrClr  = (busAddr == ADR_CLR);
      strobes.wrEoi  = (busAddr == ADR_EOI);
      strobes.wrDbg  = (busAddr == ADR_DBG);
    end else if (doRd) begin
      if (inMode)                     strobes.rdSel = SEL_MODE;
      else if (inVec)                 strobes.rdSel = SEL_VEC;
      else if (busAddr == ADR_FETCH) begin
        strobes.rdSel = SEL_FETCH;
        strobes.fetch = 1'b1;
      end
      else if (busAddr == ADR_SPUR)   strobes.rdSel = SEL_SPUR;
      else if (busAddr == ADR_MASK)   strobes.rdSel = SEL_MASK;
      else if (busAddr == ADR_DBG)    strobes.rdSel = SEL_DEBUG;
    end
  end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]             cand,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prioIn,
  output logic                           winValid,
  output logic [SRC_W-1:0]               winIdx
);

  logic [PRIO_W-1:0] bestPrio;

  // strict compare keeps the lowest index on ties
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    bestPrio = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!winValid || prioIn[i] > bestPrio)) begin
        winValid = 1'b1;
        winIdx   = SRC_W'(i);
        bestPrio = prioIn[i];
      end
    end
  end

endmodule

// File: rtl/vic_prio_stack.sv
module vic_prio_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] pushPrio,
  output logic [LVL_W-1:0]  level,
  output logic [PRIO_W-1:0] topPrio,
  output logic              empty
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [PRIO_W-1:0] slots [DEPTH];
  logic [LVL_W-1:0]  count;
  logic              full;
  logic              doPush;
  logic              doPop;
  logic [LVL_W-1:0]  topPos;

  assign full   = (count == FULL_LVL);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign topPos = count - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       count <= '0;
    else if (doPush) count <= count + 1'b1;
    else if (doPop)  count <= count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (doPush) slots[count[PTR_W-1:0]] <= pushPrio;
  end

  assign topPrio = empty ? '0 : slots[topPos[PTR_W-1:0]];
  assign level   = count;

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 PRIO_W      = 3,
  parameter int                 STACK_DEPTH = 8,
  parameter int                 DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] EXT_MASK    = 'hE000_0000,
  parameter int                 FAST_SRC    = 0,
  localparam int                SRC_W       = $clog2(NUM_SRC),
  localparam int                LVL_W       = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              strobes,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] enMask,
  output logic [LVL_W-1:0]   stackLevel
);

  logic [NUM_SRC-1:0]             enable;
  logic [NUM_SRC-1:0]             prevIn;
  logic [NUM_SRC-1:0]             pending;
  logic [NUM_SRC-1:0]             above;
  logic [NUM_SRC-1:0]             cand;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioArr;
  logic [NUM_SRC-1:0][1:0]        typeArr;
  logic [NUM_SRC-1:0][DATA_W-1:0] vecArr;
  logic [DATA_W-1:0]              spurVec;
  logic [1:0]                     dbgReg;
  logic                           winValid;
  logic [SRC_W-1:0]               winIdx;
  logic                           fetchWin;
  logic [PRIO_W-1:0]              topPrio;
  logic                           stackEmpty;

  assign fetchWin = strobes.fetch && winValid;

  // enable set/clear commands
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enable <= '0;
    else if (strobes.wrEna) enable <= enable | busWdata[NUM_SRC-1:0];
    else if (strobes.wrDis) enable <= enable & ~busWdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= srcIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spurVec <= '0;
      dbgReg  <= '0;
    end else begin
      if (strobes.wrSpur) spurVec <= busWdata;
      if (strobes.wrDbg)  dbgReg  <= busWdata[1:0];
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    localparam bit LOW_OK = EXT_MASK[i] || (i == FAST_SRC);

    logic [PRIO_W-1:0] modePrio;
    logic [1:0]        modeType;
    logic [DATA_W-1:0] vecVal;
    logic              latch;
    logic              selHere;
    logic              typeOk;
    logic              edgeHit;
    logic              levelOn;

    assign selHere = (strobes.idx == 6'(i));
    assign typeOk  = LOW_OK || !busWdata[5];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modePrio <= '0;
        modeType <= TRIG_HIGH;
      end else if (strobes.wrMode && selHere) begin
        modePrio <= busWdata[PRIO_W-1:0];
        if (typeOk) modeType <= busWdata[5:4];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         vecVal <= '0;
      else if (strobes.wrVec && selHere) vecVal <= busWdata;
    end

    assign edgeHit = modeType[1] ? (prevIn[i] && !srcIn[i]) : (srcIn[i] && !prevIn[i]);
    assign levelOn = modeType[1] ? !srcIn[i] : srcIn[i];

    // a fresh edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        latch <= 1'b0;
      else if (modeType[0] && edgeHit)
        latch <= 1'b1;
      else if ((strobes.wrClr && busWdata[i]) || (fetchWin && winIdx == SRC_W'(i)))
        latch <= 1'b0;
    end

    assign pending[i] = modeType[0] ? latch : levelOn;
    assign above[i]   = stackEmpty || (modePrio > topPrio);
    assign prioArr[i] = modePrio;
    assign typeArr[i] = modeType;
    assign vecArr[i]  = vecVal;
  end

  assign cand = pending & enable & above;

  vic_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) uArb (
    .cand     (cand),
    .prioIn   (prioArr),
    .winValid (winValid),
    .winIdx   (winIdx)
  );

  vic_prio_stack #(
    .DEPTH  (STACK_DEPTH),
    .PRIO_W (PRIO_W)
  ) uStack (
    .clk      (clk),
    .rstN     (rstN),
    .push     (fetchWin),
    .pop      (strobes.wrEoi),
    .pushPrio (prioArr[winIdx]),
    .level    (stackLevel),
    .topPrio  (topPrio),
    .empty    (stackEmpty)
  );

  always_comb begin
    busRdata = '0;
    unique case (strobes.rdSel)
      SEL_MODE: begin
        busRdata[PRIO_W-1:0] = prioArr[strobes.idx[SRC_W-1:0]];
        busRdata[5:4]        = typeArr[strobes.idx[SRC_W-1:0]];
      end
      SEL_VEC:   busRdata = vecArr[strobes.idx[SRC_W-1:0]];
      SEL_FETCH: busRdata = winValid ? vecArr[winIdx] : spurVec;
      SEL_SPUR:  busRdata = spurVec;
      SEL_MASK:  busRdata[NUM_SRC-1:0] = enable;
      SEL_DEBUG: busRdata[1:0] = dbgReg;
      default:   busRdata = '0;
    endcase
  end

  assign irqOut = winValid;
  assign enMask = enable;

endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int                 NUM_SRC     = 32,
  parameter int                 PRIO_W      = 3,
  parameter int                 STACK_DEPTH = 8,
  parameter int                 DATA_W      = 32,
  parameter logic [NUM_SRC-1:0] EXT_MASK    = 'hE000_0000,
  parameter int                 FAST_SRC    = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [7:0]         busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  localparam int LVL_W = $clog2(STACK_DEPTH + 1);

  ctrl_t              strobes;
  logic [NUM_SRC-1:0] enMask;
  logic [LVL_W-1:0]   stackLevel;

  vic_ctrl #(
    .NUM_SRC (NUM_SRC)
  ) uCtrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  vic_datapath #(
    .NUM_SRC     (NUM_SRC),
    .PRIO_W      (PRIO_W),
    .STACK_DEPTH (STACK_DEPTH),
    .DATA_W      (DATA_W),
    .EXT_MASK    (EXT_MASK),
    .FAST_SRC    (FAST_SRC)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWdata   (busWdata),
    .srcIn      (srcIn),
    .busRdata   (busRdata),
    .irqOut     (irqOut),
    .enMask     (enMask),
    .stackLevel (stackLevel)
  );

endmodule

// File: rtl/vic_checks.sv
module vic_checks
  import vic_pkg::*;
#(
  parameter int  NUM_SRC     = 32,
  parameter int  PRIO_W      = 3,
  parameter int  STACK_DEPTH = 8,
  parameter int  DATA_W      = 32,
  localparam int LVL_W       = $clog2(STACK_DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic               busRdEn,
  input logic [7:0]         busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] enMask,
  input logic [LVL_W-1:0]   stackLevel
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(STACK_DEPTH);
  localparam bit LEVELS_FIT = (STACK_DEPTH >= (1 << PRIO_W));

  logic isFetch;
  logic isEoi;
  logic isEna;
  logic isDis;

  assign isFetch = busRdEn && !busWrEn && (busAddr == ADR_FETCH);
  assign isEoi   = busWrEn && (busAddr == ADR_EOI);
  assign isEna   = busWrEn && (busAddr == ADR_ENA);
  assign isDis   = busWrEn && (busAddr == ADR_DIS);

  assert_enable_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    isEna |=> ((enMask & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0])));

  assert_disable_clr_R1: assert property (@(posedge clk) disable iff (!rstN)
    isDis |=> ((enMask & $past(busWdata[NUM_SRC-1:0])) == '0));

  assert_zero_bits_kept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (isEna || isDis) |=> ((enMask & ~$past(busWdata[NUM_SRC-1:0])) ==
                          ($past(enMask) & ~$past(busWdata[NUM_SRC-1:0]))));

  assert_spurious_no_push_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isFetch && !irqOut) |=> $stable(stackLevel));

  assert_quiet_when_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (enMask == '0) |-> !irqOut);

  assert_fetch_push_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isFetch && irqOut) |=> (stackLevel == LVL_W'($past(stackLevel) + 1'b1)));

  assert_eoi_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isEoi && stackLevel != '0) |=> (stackLevel == LVL_W'($past(stackLevel) - 1'b1)));

  assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isEoi && stackLevel == '0) |=> (stackLevel == '0));

  assert_stack_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    stackLevel <= FULL_LVL);

  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (LEVELS_FIT && stackLevel == FULL_LVL) |-> !irqOut);

endmodule

bind vic_top vic_checks #(
  .NUM_SRC     (NUM_SRC),
  .PRIO_W      (PRIO_W),
  .STACK_DEPTH (STACK_DEPTH),
  .DATA_W      (DATA_W)
) uChecks (
  .clk        (clk),
  .rstN       (rstN),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .irqOut     (irqOut),
  .enMask     (enMask),
  .stackLevel (stackLevel)
);

// File: tb/tb_vic_top.sv
module tb_vic_top;

  localparam logic [7:0] A_FETCH = 8'h80;
  localparam logic [7:0] A_SPUR  = 8'h81;
  localparam logic [7:0] A_ENA   = 8'h82;
  localparam logic [7:0] A_DIS   = 8'h83;
  localparam logic [7:0] A_CLR   = 8'h84;
  localparam logic [7:0] A_MASK  = 8'h85;
  localparam logic [7:0] A_EOI   = 8'h86;
  localparam logic [7:0] A_DBG   = 8'h87;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] srcIn = '0;
  logic        irqOut;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vic_top dut (
    .clk      (clk),
    .rstN     (rstN),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .srcIn    (srcIn),
    .irqOut   (irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic setSrc(input int k, input logic v);
    @(negedge clk);
    srcIn[k] = v;
    @(negedge clk);
    #1;
  endtask

  task automatic chkIrq(input string tag, input logic exp);
    #1 chk(tag, {31'b0, irqOut}, {31'b0, exp});
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRd(A_MASK, d);  chk("R11 mask after reset", d, 32'h0);
    chkIrq("R11 irq after reset", 1'b0);
    busRd(A_FETCH, d); chk("R11 fetch gives zero spurious", d, 32'h0);
    busRd(8'h05, d);   chk("R11 mode word zero", d, 32'h0);
    busRd(8'h45, d);   chk("R11 vector word zero", d, 32'h0);
  endtask

  task automatic testMask();
    logic [31:0] d;
    busWr(A_ENA, 32'hF0);
    busWr(A_DIS, 32'h30);
    busRd(A_MASK, d); chk("R1 set then clear", d, 32'hC0);
    busWr(A_ENA, 32'h01);
    busRd(A_MASK, d); chk("R1 zero bits kept", d, 32'hC1);
    busWr(A_DIS, 32'hFFFF_FFFF);
    busRd(A_MASK, d); chk("R1 disable all", d, 32'h0);
  endtask

  task automatic testMode();
    logic [31:0] d;
    busWr(8'h05, 32'h16);
    busRd(8'h05, d); chk("R3 mode readback", d, 32'h16);
    busWr(8'h05, 32'h23);
    busRd(8'h05, d); chk("R4 internal rejects low type", d, 32'h13);
    busWr(8'h1D, 32'h32);
    busRd(8'h1D, d); chk("R4 external accepts falling", d, 32'h32);
    busWr(8'h00, 32'h21);
    busRd(8'h00, d); chk("R4 fast line accepts low", d, 32'h21);
    busWr(8'h00, 32'h00);
    busWr(8'h45, 32'h105);
    busRd(8'h45, d); chk("R3 vector readback", d, 32'h105);
  endtask

  task automatic testLevel();
    busWr(8'h03, 32'h02);
    busWr(8'h43, 32'h103);
    busWr(A_ENA, 32'h08);
    chkIrq("R8 idle line no irq", 1'b0);
    setSrc(3, 1'b1); chkIrq("R5 high level requests", 1'b1);
    setSrc(3, 1'b0); chkIrq("R5 level drops with input", 1'b0);
  endtask

  task automatic testEdgeNest();
    logic [31:0] d;
    busWr(A_ENA, 32'h20);
    setSrc(5, 1'b1); setSrc(5, 1'b0);
    chkIrq("R5 rising edge latched", 1'b1);
    busWr(A_CLR, 32'h20); chkIrq("R2 clear drops edge", 1'b0);
    setSrc(3, 1'b1);
    busWr(A_CLR, 32'h08); chkIrq("R2 clear ignores level", 1'b1);
    busRd(A_FETCH, d); chk("R6 fetch level line", d, 32'h103);
    chkIrq("R8 equal priority blocked", 1'b0);
    setSrc(5, 1'b1); setSrc(5, 1'b0);
    chkIrq("R8 higher priority nests", 1'b1);
    busRd(A_FETCH, d); chk("R6 nested fetch", d, 32'h105);
    chkIrq("R9 winner edge cleared", 1'b0);
    busWr(A_EOI, 0); chkIrq("R10 one pop leaves level2", 1'b0);
    busWr(A_EOI, 0); chkIrq("R10 stack empty again", 1'b1);
    setSrc(3, 1'b0);
    busWr(A_EOI, 0);
    setSrc(3, 1'b1);
    busRd(A_FETCH, d); chk("R10 fetch after empty pop", d, 32'h103);
    chkIrq("R10 empty pop ignored", 1'b0);
    busWr(A_EOI, 0); chkIrq("R10 single pop empties", 1'b1);
    setSrc(3, 1'b0);
    busWr(A_DIS, 32'hFFFF_FFFF);
  endtask

  task automatic testTieSpur();
    logic [31:0] d;
    busWr(8'h07, 32'h04); busWr(8'h09, 32'h04);
    busWr(8'h47, 32'h107); busWr(8'h49, 32'h109);
    srcIn[7] = 1'b1; srcIn[9] = 1'b1;
    busWr(A_ENA, 32'h280);
    busRd(A_FETCH, d); chk("R6 tie lowest index", d, 32'h107);
    busWr(A_EOI, 0);
    busWr(8'h09, 32'h05);
    busRd(A_FETCH, d); chk("R6 higher priority wins", d, 32'h109);
    chkIrq("R8 lower priority blocked", 1'b0);
    busWr(A_SPUR, 32'hDEAD);
    busRd(A_FETCH, d); chk("R7 spurious when blocked", d, 32'hDEAD);
    busWr(A_EOI, 0); chkIrq("R7 spurious did not push", 1'b1);
    busWr(A_DIS, 32'hFFFF_FFFF);
    srcIn[7] = 1'b0; srcIn[9] = 1'b0;
    busRd(A_FETCH, d); chk("R7 spurious when idle", d, 32'hDEAD);
    chkIrq("R7 idle no irq", 1'b0);
  endtask

  task automatic testDepth();
    logic [31:0] d;
    for (int k = 10; k < 18; k++) begin
      busWr(8'(k), 32'(k - 10));
      busWr(8'(8'h40 + k), 32'(32'h100 + k));
      srcIn[k] = 1'b1;
    end
    for (int k = 10; k < 18; k++) begin
      busWr(A_ENA, 32'(1) << k);
      busRd(A_FETCH, d); chk("R10 nested fetch level", d, 32'(32'h100 + k));
    end
    chkIrq("R10 full stack no irq", 1'b0);
    busWr(A_EOI, 0); chkIrq("R10 pop re-opens top", 1'b1);
    for (int k = 0; k < 8; k++) busWr(A_EOI, 0);
    busRd(A_FETCH, d); chk("R6 best of eight", d, 32'h111);
    busWr(A_EOI, 0);
    busWr(A_DIS, 32'hFFFF_FFFF);
    srcIn[17:10] = '0;
  endtask

  task automatic testFallLow();
    logic [31:0] d;
    busWr(8'h5D, 32'h129);
    busWr(A_ENA, 32'h2000_0000);
    setSrc(29, 1'b1); chkIrq("R5 rise ignored on falling line", 1'b0);
    setSrc(29, 1'b0); chkIrq("R5 falling edge latched", 1'b1);
    busRd(A_FETCH, d); chk("R6 falling line vector", d, 32'h129);
    chkIrq("R9 falling latch cleared", 1'b0);
    busWr(A_EOI, 0);
    busWr(A_DIS, 32'hFFFF_FFFF);
    busWr(8'h00, 32'h21);
    busWr(A_ENA, 32'h1); chkIrq("R5 low level requests", 1'b1);
    setSrc(0, 1'b1); chkIrq("R5 low level released", 1'b0);
    busWr(A_DIS, 32'hFFFF_FFFF);
  endtask

  task automatic testDebug();
    logic [31:0] d;
    busWr(A_DBG, 32'h3);
    busRd(A_DBG, d); chk("R12 debug readback", d, 32'h3);
    chkIrq("R12 debug no irq", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMask();
    testMode();
    testLevel();
    testEdgeNest();
    testTieSpur();
    testDepth();
    testFallLow();
    testDebug();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

endmodule